// File: doc/BRIEF.md
# Eight-Operation Small-Operand ALU

This block is a purely combinational arithmetic unit. It reads two unsigned operands, four bits each by default, plus a three-bit operation code. It returns a result one bit wider than the operands. Its datapath offers eight operations:

- copying the first operand
- sum
- difference
- quotient
- remainder
- left and right single-bit shifts
- a strict magnitude comparison

There are no flags. Whatever does not fit in the result width is dropped. A zero divisor yields fixed, defined values, so the output never carries unknown bits.

The unit has no clock and no state. A change on any input reaches the output within the same cycle. It fits where a small control path needs divide and compare next to add and subtract without a full-width datapath.

Top module: `alu8_core`

## Requirements
- R1: Operation code 3'b000 drives the first operand, zero-extended, onto the result.
- R2: Code 3'b001 drives the sum of the operands, keeping its low result-width bits.
- R3: Code 3'b010 drives the difference first minus second, taken modulo 2^(result width), so a smaller first operand wraps (0 minus 1 gives 5'b11111).
- R4: Code 3'b011 drives the unsigned integer quotient, zero-extended, when the divisor is non-zero.
- R5: Code 3'b100 drives the unsigned remainder, zero-extended, when the divisor is non-zero.
- R6: With a zero second operand, code 3'b011 drives all ones (5'b11111) and code 3'b100 drives the first operand zero-extended.
- R7: Code 3'b101 drives the first operand shifted left by one. The low bit is zero and the top result bit holds the operand's old top bit.
- R8: Code 3'b110 drives the first operand shifted right by one, with zeros filling the upper bits.
- R9: Code 3'b111 drives 1 when the first operand is strictly greater than the second and 0 otherwise, with all upper result bits zero.
- R10: The result follows any input change without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | OPND_W (4) | First operand, unsigned |
| b_i | input | OPND_W (4) | Second operand / divisor, unsigned |
| op_i | input | 3 | Operation code |
| y_o | output | OPND_W+1 (5) | Result |

## Verification
The bench builds the unit with the default operand width of four bits. At that width the whole input space is small: 8 codes times 256 operand pairs. The bench therefore sweeps every combination against its own integer-arithmetic model. This sweep reaches each wrap of the difference and every zero-divisor case. It also reaches every carry out of the sum and the shift, and both sides of the comparison including equal operands. A short table of hand-worked vectors pins the boundary values first.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 3'b000,
    OP_ADD  = 3'b001,
    OP_SUB  = 3'b010,
    OP_DIV  = 3'b011,
    OP_MOD  = 3'b100,
    OP_SHL  = 3'b101,
    OP_SHR  = 3'b110,
    OP_GT   = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int OPND_W = 4,
  localparam int RES_W = OPND_W + 1
) (
  input  logic [OPND_W-1:0] a_i,
  input  logic [OPND_W-1:0] b_i,
  output logic [RES_W-1:0]  sum_o,
  output logic [RES_W-1:0]  diff_o
);
  function automatic logic [RES_W-1:0] f_add(input logic [OPND_W-1:0] x, input logic [OPND_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [RES_W-1:0] f_sub(input logic [OPND_W-1:0] x, input logic [OPND_W-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  assign sum_o  = f_add(a_i, b_i);
  assign diff_o = f_sub(a_i, b_i);

  logic [RES_W-1:0] diff_back;
  assign diff_back = diff_o + {1'b0, b_i};

  always_comb begin
    // adding the subtrahend back must recover the minuend modulo 2^RES_W
    a_r3_sub_wrap: assert (diff_back == {1'b0, a_i});
    // the sum is always at least as large as either operand (no loss at this width)
    a_r2_add_bound: assert (sum_o >= {1'b0, a_i});
  end
endmodule

// File: rtl/alu8_divmod.sv
module alu8_divmod #(
  parameter int OPND_W = 4,
  localparam int RES_W = OPND_W + 1
) (
  input  logic [OPND_W-1:0] a_i,
  input  logic [OPND_W-1:0] b_i,
  output logic [RES_W-1:0]  quo_o,
  output logic [RES_W-1:0]  rem_o,
  output logic              div_zero_o
);
  logic [OPND_W-1:0] b_safe;

  function automatic logic [RES_W-1:0] f_quo(input logic [OPND_W-1:0] x, input logic [OPND_W-1:0] y);
    return {1'b0, x / y};
  endfunction

  function automatic logic [RES_W-1:0] f_rem(input logic [OPND_W-1:0] x, input logic [OPND_W-1:0] y);
    return {1'b0, x % y};
  endfunction

  assign div_zero_o = (b_i == '0);
  assign b_safe     = div_zero_o ? {{(OPND_W-1){1'b0}}, 1'b1} : b_i;
  assign quo_o      = div_zero_o ? {RES_W{1'b1}} : f_quo(a_i, b_safe);
  assign rem_o      = div_zero_o ? {1'b0, a_i}   : f_rem(a_i, b_safe);

  always_comb begin
    if (!div_zero_o) begin
      // quotient times divisor plus remainder reconstructs the dividend
      a_r4_div_recon: assert ((int'(quo_o) * int'(b_i) + int'(rem_o)) == int'(a_i));
      // remainder strictly below divisor
      a_r5_rem_range: assert (int'(rem_o) < int'(b_i));
    end else begin
      a_r6_div_zero: assert (&quo_o && rem_o == {1'b0, a_i});
    end
  end
endmodule

// File: rtl/alu8_shcmp.sv
module alu8_shcmp #(
  parameter int OPND_W = 4,
  localparam int RES_W = OPND_W + 1
) (
  input  logic [OPND_W-1:0] a_i,
  input  logic [OPND_W-1:0] b_i,
  output logic [RES_W-1:0]  shl_o,
  output logic [RES_W-1:0]  shr_o,
  output logic [RES_W-1:0]  gt_o
);
  function automatic logic [RES_W-1:0] f_shl(input logic [OPND_W-1:0] x);
    return {x, 1'b0};
  endfunction

  function automatic logic [RES_W-1:0] f_shr(input logic [OPND_W-1:0] x);
    return {2'b00, x[OPND_W-1:1]};
  endfunction

  function automatic logic [RES_W-1:0] f_gt(input logic [OPND_W-1:0] x, input logic [OPND_W-1:0] y);
    return {{OPND_W{1'b0}}, (x > y)};
  endfunction

  assign shl_o = f_shl(a_i);
  assign shr_o = f_shr(a_i);
  assign gt_o  = f_gt(a_i, b_i);

  always_comb begin
    // left shift is doubling with no loss at this width
    a_r7_shl_double: assert (int'(shl_o) == 2 * int'(a_i));
    // right shift is floor halving
    a_r8_shr_half: assert (int'(shr_o) == int'(a_i) / 2);
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int OPND_W = 4,
  localparam int RES_W = OPND_W + 1
) (
  input  logic [OPND_W-1:0]          a_i,
  input  logic [OPND_W-1:0]          b_i,
  input  logic [alu8_pkg::OP_W-1:0]  op_i,
  output logic [RES_W-1:0]           y_o
);
  import alu8_pkg::*;

  logic [RES_W-1:0] sum_w, diff_w, quo_w, rem_w, shl_w, shr_w, gt_w;
  logic             div_zero_w;
  alu_op_e          op_e;

  alu8_addsub #(.OPND_W(OPND_W)) addsub_i (
    .a_i(a_i), .b_i(b_i), .sum_o(sum_w), .diff_o(diff_w)
  );

  alu8_divmod #(.OPND_W(OPND_W)) divmod_i (
    .a_i(a_i), .b_i(b_i), .quo_o(quo_w), .rem_o(rem_w), .div_zero_o(div_zero_w)
  );

  alu8_shcmp #(.OPND_W(OPND_W)) shcmp_i (
    .a_i(a_i), .b_i(b_i), .shl_o(shl_w), .shr_o(shr_w), .gt_o(gt_w)
  );

  assign op_e = alu_op_e'(op_i);

  always_comb begin
    unique case (op_e)
      OP_PASS: y_o = {1'b0, a_i};
      OP_ADD:  y_o = sum_w;
      OP_SUB:  y_o = diff_w;
      OP_DIV:  y_o = quo_w;
      OP_MOD:  y_o = rem_w;
      OP_SHL:  y_o = shl_w;
      OP_SHR:  y_o = shr_w;
      OP_GT:   y_o = gt_w;
      default: y_o = '0;
    endcase
  end

  always_comb begin
    if (op_e == OP_PASS)
      a_r1_pass: assert (y_o[RES_W-1:1] == {1'b0, a_i[OPND_W-1:1]} && y_o[0] == a_i[0]);
    if (op_e == OP_GT) begin
      a_r9_cmp_ext: assert (y_o[RES_W-1:1] == '0);
      a_r9_cmp_val: assert (y_o[0] == (int'(a_i) > int'(b_i)));
    end
    if (op_e == OP_DIV && div_zero_w)
      a_r6_div_zero_out: assert (&y_o);
  end
endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  localparam int OPND_W = 4;
  localparam int RES_W  = OPND_W + 1;
  localparam int NVEC   = 14;

  // {op[2:0], a[3:0], b[3:0], expected[4:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {3'b000, 4'd15, 4'd3,  5'd15},  // R1
    {3'b001, 4'd15, 4'd15, 5'd30},  // R2 max sum
    {3'b001, 4'd9,  4'd8,  5'd17},  // R2 carry
    {3'b010, 4'd0,  4'd1,  5'd31},  // R3 wrap
    {3'b010, 4'd0,  4'd15, 5'd17},  // R3 deepest wrap
    {3'b011, 4'd15, 4'd4,  5'd3},   // R4
    {3'b100, 4'd15, 4'd4,  5'd3},   // R5
    {3'b011, 4'd7,  4'd0,  5'd31},  // R6
    {3'b100, 4'd13, 4'd0,  5'd13},  // R6
    {3'b101, 4'd9,  4'd0,  5'd18},  // R7 top bit kept
    {3'b110, 4'd9,  4'd0,  5'd4},   // R8
    {3'b111, 4'd5,  4'd5,  5'd0},   // R9 equal
    {3'b111, 4'd6,  4'd5,  5'd1},   // R9 greater
    {3'b111, 4'd0,  4'd15, 5'd0}    // R9 smaller
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [OPND_W-1:0] a, b;
  logic [2:0]        op;
  logic [RES_W-1:0]  y;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  alu8_core #(.OPND_W(OPND_W)) dut_i (.a_i(a), .b_i(b), .op_i(op), .y_o(y));

  function automatic int ref_model(input int o, input int x, input int z);
    case (o)
      0: return x;
      1: return (x + z) % 32;
      2: return (x - z + 32) % 32;
      3: return (z == 0) ? 31 : x / z;
      4: return (z == 0) ? x : x % z;
      5: return (x * 2) % 32;
      6: return x / 2;
      default: return (x > z) ? 1 : 0;
    endcase
  endfunction

  function automatic string req_of(input int o, input int z);
    if ((o == 3 || o == 4) && z == 0) return "R6";
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%0d b=%0d got=%0d exp=%0d", req, op, a, b, got, exp);
    end
  endtask

  initial begin
    a = '0; b = '0; op = '0;
    @(negedge clk);
    check("R1", int'(y), 0);  // settled state with all-zero inputs

    for (int i = 0; i < NVEC; i++) begin
      op = VEC[i][15:13]; a = VEC[i][12:9]; b = VEC[i][8:5];
      #1;
      check(req_of(int'(op), int'(b)), int'(y), int'(VEC[i][4:0]));
    end

    // R10: result changes with no clock edge in between
    @(posedge clk); #0.5;
    op = 3'b001; a = 4'd3; b = 4'd4;
    #0.5;
    check("R10", int'(y), 7);
    a = 4'd10;
    #0.5;
    check("R10", int'(y), 14);

    for (int o = 0; o < 8; o++)
      for (int x = 0; x < 16; x++)
        for (int z = 0; z < 16; z++) begin
          op = o[2:0]; a = x[3:0]; b = z[3:0];
          #1;
          check(req_of(o, z), int'(y), ref_model(o, x, z));
        end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule